// File: doc/BRIEF.md
# Loop Requeue Stage Controller

This block sits in front of a circular instruction FIFO and decides, every cycle, which of its two incoming instruction streams reaches the FIFO. The first stream carries new instructions arriving from the network. The second stream carries instructions leaving the FIFO's far end, which may be fed back for another pass. Each stream is a valid/ready channel with an instruction word and two decoded tags. One tag marks the first instruction of a loop body (head) and the other marks the end of one (tail).

The controller has two modes. In fill mode it loads a new loop body. Fresh instructions are forwarded, and the previous body coming back around is thrown away. In loop mode the FIFO contents circulate and new instructions are shut out. The controller enters loop mode only when two markers meet in the same cycle: a tail waiting on the fresh side and a head waiting on the feedback side. Both markers are then swallowed. A single-cycle abort pulse from the execute stage forces the controller back into fill mode. That pulse is raised only for an abort whose predicate held.

The controller adds no storage for instruction words. All readies and the output are combinational, and the only flop is the mode bit.

Top module: `loopq_requeue`

## Requirements
- R1: After reset the controller is in fill mode; the `looping` output is 0 (1 means loop mode).
- R2: In fill mode an enqueue item whose tail tag is 0 is presented at the output with its word and tags unchanged, and `enq_ready` equals `out_ready`; a tail-tagged enqueue item is never presented at the output.
- R3: In fill mode a feedback item whose head tag is 0 is accepted (`rcq_ready` = 1) whatever `out_ready` is, and it never reaches the output.
- R4: In fill mode a tail-tagged enqueue item holds (`enq_ready` = 0) and a head-tagged feedback item holds (`rcq_ready` = 0), for as long as the other marker is absent.
- R5: When a tail-tagged enqueue item and a head-tagged feedback item are both valid in fill mode, both readies are 1 in that cycle and `out_valid` is 0. Without an abort, `looping` is 1 from the next cycle.
- R6: In loop mode `enq_ready` is always 0.
- R7: In loop mode every feedback item, tagged or not, is presented at the output: `out_valid` equals `rcq_valid`, the word and tags are passed through, and `rcq_ready` equals `out_ready`.
- R8: An `abort_hit` pulse in loop mode returns the controller to fill mode in the next cycle.
- R9: An `abort_hit` pulse in fill mode, without a marker meeting, has no effect: the mode stays fill and forwarding continues as in R2.
- R10: An `abort_hit` pulse in the same cycle as a marker meeting still consumes both markers, and the controller is in fill mode in the next cycle.
- R11: In fill mode, when an enqueue item is forwarded and a non-head feedback item is valid in the same cycle, the feedback item is dropped and the output carries the enqueue item.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enq_valid | input | 1 | Fresh instruction is valid |
| enq_ready | output | 1 | Fresh instruction taken this cycle |
| enq_word | input | W | Fresh instruction word |
| enq_head | input | 1 | Fresh instruction is a loop head |
| enq_tail | input | 1 | Fresh instruction is a loop tail |
| rcq_valid | input | 1 | Feedback instruction is valid |
| rcq_ready | output | 1 | Feedback instruction taken (forwarded or dropped) |
| rcq_word | input | W | Feedback instruction word |
| rcq_head | input | 1 | Feedback instruction is a loop head |
| rcq_tail | input | 1 | Feedback instruction is a loop tail |
| out_valid | output | 1 | Item presented to the FIFO |
| out_ready | input | 1 | FIFO accepts the item |
| out_word | output | W | Word presented to the FIFO |
| out_head | output | 1 | Head tag presented to the FIFO |
| out_tail | output | 1 | Tail tag presented to the FIFO |
| abort_hit | input | 1 | Abort with satisfied predicate, one-cycle pulse |
| looping | output | 1 | 1 in loop mode, 0 in fill mode |

## Verification
The bench parks a lone tail and then a lone head at the inputs to confirm that neither slips through. A design that accepted a lone marker would lose it, or would enter loop mode early. It presents both markers together and checks the swallow cycle and the mode change that follows. It repeats that meeting with an abort in the same cycle, where a design that ranked the meeting above the abort would wrongly stay in loop mode. Other stimuli cover the following failures:
- An abort in fill mode must be ignored.
- Fresh items must be locked out in loop mode, including during output backpressure.
- Fresh and feedback items arriving together in fill mode must resolve so that the feedback item is dropped, not forwarded or held.

// File: rtl/loopq_pkg.sv
`timescale 1ns/1ps
package loopq_pkg;

  // Controller mode: fill loads a new body, loop circulates the FIFO.
  typedef enum logic {
    RQ_FILL = 1'b0,
    RQ_LOOP = 1'b1
  } rq_mode_e;

  // Which input drives the output this cycle.
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ENQ  = 2'd1,
    SRC_RCQ  = 2'd2
  } rq_src_e;

endpackage

// File: rtl/loopq_mode_ctl.sv
`timescale 1ns/1ps
module loopq_mode_ctl
  import loopq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     meet,
  input  logic     abort_hit,
  output rq_mode_e mode
);

  rq_mode_e mode_q;
  rq_mode_e mode_nx;
  logic     mode_en;

  // Next state: a marker meeting enters loop mode, abort wins over it.
  always_comb begin
    mode_en = meet | abort_hit;
    mode_nx = mode_q;
    if (meet)      mode_nx = RQ_LOOP;
    if (abort_hit) mode_nx = RQ_FILL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RQ_FILL;
    end else if (mode_en) begin
      mode_q <= mode_nx;
    end
  end

  assign mode = mode_q;

endmodule

// File: rtl/loopq_steer.sv
`timescale 1ns/1ps
module loopq_steer
  import loopq_pkg::*;
(
  input  rq_mode_e mode,
  input  logic     enq_valid,
  input  logic     enq_tail,
  input  logic     rcq_valid,
  input  logic     rcq_head,
  input  logic     out_ready,
  output logic     enq_ready,
  output logic     rcq_ready,
  output logic     out_valid,
  output rq_src_e  src,
  output logic     meet
);

  logic tail_waiting;
  logic head_waiting;
  logic enq_fwd;

  always_comb begin
    tail_waiting = enq_valid & enq_tail;
    head_waiting = rcq_valid & rcq_head;
    enq_fwd      = enq_valid & ~enq_tail;
    meet         = 1'b0;
    enq_ready    = 1'b0;
    rcq_ready    = 1'b0;
    out_valid    = 1'b0;
    src          = SRC_NONE;
    if (mode == RQ_FILL) begin
      meet      = tail_waiting & head_waiting;
      out_valid = enq_fwd;
      src       = enq_fwd ? SRC_ENQ : SRC_NONE;
      enq_ready = (enq_fwd & out_ready) | meet;
      rcq_ready = (rcq_valid & ~rcq_head) | meet;
    end else begin
      out_valid = rcq_valid;
      src       = SRC_RCQ;
      rcq_ready = out_ready;
    end
  end

endmodule

// File: rtl/loopq_out_mux.sv
`timescale 1ns/1ps
module loopq_out_mux
  import loopq_pkg::*;
#(
  parameter int W         = 25,
  parameter bit ZERO_IDLE = 1'b1
) (
  input  rq_src_e      src,
  input  logic [W-1:0] enq_word,
  input  logic         enq_head,
  input  logic         enq_tail,
  input  logic [W-1:0] rcq_word,
  input  logic         rcq_head,
  input  logic         rcq_tail,
  output logic [W-1:0] out_word,
  output logic         out_head,
  output logic         out_tail
);

  localparam int PW = W + 2;

  logic [PW-1:0] enq_pk;
  logic [PW-1:0] rcq_pk;
  logic [PW-1:0] out_pk;

  assign enq_pk = {enq_head, enq_tail, enq_word};
  assign rcq_pk = {rcq_head, rcq_tail, rcq_word};

  generate
    if (ZERO_IDLE) begin : g_zero_idle
      // Idle output is all zero so nothing downstream sees stale tags.
      always_comb begin
        case (src)
          SRC_ENQ: out_pk = enq_pk;
          SRC_RCQ: out_pk = rcq_pk;
          default: out_pk = '0;
        endcase
      end
    end else begin : g_two_way
      // Cheaper two-way select; idle output mirrors the enqueue side.
      always_comb begin
        out_pk = (src == SRC_RCQ) ? rcq_pk : enq_pk;
      end
    end
  endgenerate

  assign out_word = out_pk[W-1:0];
  assign out_tail = out_pk[W];
  assign out_head = out_pk[W+1];

endmodule

// File: rtl/loopq_requeue.sv
`timescale 1ns/1ps
module loopq_requeue
  import loopq_pkg::*;
#(
  parameter int W         = 25,
  parameter bit ZERO_IDLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enq_valid,
  output logic         enq_ready,
  input  logic [W-1:0] enq_word,
  input  logic         enq_head,
  input  logic         enq_tail,
  input  logic         rcq_valid,
  output logic         rcq_ready,
  input  logic [W-1:0] rcq_word,
  input  logic         rcq_head,
  input  logic         rcq_tail,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_word,
  output logic         out_head,
  output logic         out_tail,
  input  logic         abort_hit,
  output logic         looping
);

  rq_mode_e mode;
  rq_src_e  src;
  logic     meet;

  loopq_mode_ctl u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .meet      (meet),
    .abort_hit (abort_hit),
    .mode      (mode)
  );

  loopq_steer u_steer (
    .mode      (mode),
    .enq_valid (enq_valid),
    .enq_tail  (enq_tail),
    .rcq_valid (rcq_valid),
    .rcq_head  (rcq_head),
    .out_ready (out_ready),
    .enq_ready (enq_ready),
    .rcq_ready (rcq_ready),
    .out_valid (out_valid),
    .src       (src),
    .meet      (meet)
  );

  loopq_out_mux #(.W(W), .ZERO_IDLE(ZERO_IDLE)) u_mux (
    .src      (src),
    .enq_word (enq_word),
    .enq_head (enq_head),
    .enq_tail (enq_tail),
    .rcq_word (rcq_word),
    .rcq_head (rcq_head),
    .rcq_tail (rcq_tail),
    .out_word (out_word),
    .out_head (out_head),
    .out_tail (out_tail)
  );

  assign looping = (mode == RQ_LOOP);

endmodule

// File: rtl/loopq_requeue_chk.sv
`timescale 1ns/1ps
module loopq_requeue_chk #(
  parameter int W = 25
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enq_valid,
  input logic         enq_ready,
  input logic         enq_tail,
  input logic         rcq_valid,
  input logic         rcq_ready,
  input logic         rcq_head,
  input logic [W-1:0] rcq_word,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_word,
  input logic         out_tail,
  input logic         abort_hit,
  input logic         looping
);

  logic both_marks;
  assign both_marks = enq_valid & enq_tail & rcq_valid & rcq_head;

  // R2
  fill_no_tail_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!looping && out_valid) |-> !out_tail);

  // R3
  fill_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!looping && rcq_valid && !rcq_head) |-> rcq_ready);

  // R4
  tail_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!looping && enq_valid && enq_tail && !(rcq_valid && rcq_head)) |-> !enq_ready);

  // R5
  enter_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!looping && both_marks && !abort_hit) |=> looping);

  // R6
  enq_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    looping |-> !enq_ready);

  // R7
  loop_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    looping |-> (out_valid == rcq_valid && rcq_ready == out_ready &&
                 (!rcq_valid || out_word == rcq_word)));

  // R8
  abort_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |=> !looping);

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!abort_hit && !both_marks) |=> (looping == $past(looping)));

endmodule

bind loopq_requeue loopq_requeue_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enq_valid (enq_valid),
  .enq_ready (enq_ready),
  .enq_tail  (enq_tail),
  .rcq_valid (rcq_valid),
  .rcq_ready (rcq_ready),
  .rcq_head  (rcq_head),
  .rcq_word  (rcq_word),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  (out_word),
  .out_tail  (out_tail),
  .abort_hit (abort_hit),
  .looping   (looping)
);

// File: tb/loopq_requeue_bench.sv
`timescale 1ns/1ps
module loopq_requeue_bench;

  localparam int W = 25;

  typedef struct {
    logic [W-1:0] w;
    logic         h;
    logic         t;
    string        tag;
  } exp_item_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         enq_valid, enq_head, enq_tail;
  logic [W-1:0] enq_word;
  logic         rcq_valid, rcq_head, rcq_tail;
  logic [W-1:0] rcq_word;
  logic         out_ready, abort_hit;
  logic         enq_ready, rcq_ready, out_valid, out_head, out_tail, looping;
  logic [W-1:0] out_word;

  int n_chk  = 0;
  int n_fail = 0;
  exp_item_t exp_q[$];

  always #2.5 clk = ~clk;

  loopq_requeue #(.W(W)) u_loopq_requeue (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_word(enq_word),
    .enq_head(enq_head), .enq_tail(enq_tail),
    .rcq_valid(rcq_valid), .rcq_ready(rcq_ready), .rcq_word(rcq_word),
    .rcq_head(rcq_head), .rcq_tail(rcq_tail),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_head(out_head), .out_tail(out_tail),
    .abort_hit(abort_hit), .looping(looping)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_exp(input logic [W-1:0] w, input logic h, input logic t, input string tag);
    exp_item_t it;
    it.w = w; it.h = h; it.t = t; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // Drive one cycle of stimulus just after a rising edge, return at the falling edge.
  task automatic drive(input logic ev, input logic [W-1:0] ew, input logic eh, input logic et,
                       input logic rv, input logic [W-1:0] rw, input logic rh, input logic rt,
                       input logic ordy, input logic ab);
    @(posedge clk);
    #1;
    enq_valid = ev; enq_word = ew; enq_head = eh; enq_tail = et;
    rcq_valid = rv; rcq_word = rw; rcq_head = rh; rcq_tail = rt;
    out_ready = ordy; abort_hit = ab;
    @(negedge clk);
  endtask

  task automatic idle();
    drive(0, '0, 0, 0, 0, '0, 0, 0, 1, 0);
  endtask

  // Scoreboard monitor: every output handshake must match the next expected item.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1 && out_ready === 1'b1) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2/R7 unexpected output actual=%0h expected=none", out_word);
      end else begin
        exp_item_t it;
        it = exp_q.pop_front();
        chk({it.tag, " word"}, 32'(out_word), 32'(it.w));
        chk({it.tag, " tags"}, {30'd0, out_head, out_tail}, {30'd0, it.h, it.t});
      end
    end
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    enq_valid = 0; enq_word = '0; enq_head = 0; enq_tail = 0;
    rcq_valid = 0; rcq_word = '0; rcq_head = 0; rcq_tail = 0;
    out_ready = 1; abort_hit = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 looping after reset", 32'(looping), 32'd0);

    // R2: plain and head-tagged enqueue items forwarded
    push_exp(25'h0000A1, 0, 0, "R2 plain");
    drive(1, 25'h0000A1, 0, 0, 0, '0, 0, 0, 1, 0);
    chk("R2 enq_ready", 32'(enq_ready), 32'd1);
    push_exp(25'h1000B2, 1, 0, "R2 head-tagged");
    drive(1, 25'h1000B2, 1, 0, 0, '0, 0, 0, 1, 0);
    chk("R2 out_valid", 32'(out_valid), 32'd1);
    // R2: backpressure holds the enqueue item
    drive(1, 25'h0000C3, 0, 0, 0, '0, 0, 0, 0, 0);
    chk("R2 enq_ready under backpressure", 32'(enq_ready), 32'd0);
    chk("R2 out_valid under backpressure", 32'(out_valid), 32'd1);

    // R11: enqueue and non-head feedback together
    push_exp(25'h0000C3, 0, 0, "R11 enqueue priority");
    drive(1, 25'h0000C3, 0, 0, 1, 25'h0000D4, 0, 0, 1, 0);
    chk("R11 feedback dropped", 32'(rcq_ready), 32'd1);
    chk("R11 enq taken", 32'(enq_ready), 32'd1);

    // R3: lone feedback item dropped even with output stalled
    drive(0, '0, 0, 0, 1, 25'h0000E5, 0, 1, 0, 0);
    chk("R3 feedback accepted", 32'(rcq_ready), 32'd1);
    chk("R3 feedback not output", 32'(out_valid), 32'd0);

    // R4: lone tail stalls for several cycles
    drive(1, 25'h0000F6, 0, 1, 0, '0, 0, 0, 1, 0);
    chk("R4 tail stalls", 32'(enq_ready), 32'd0);
    chk("R4 tail not output", 32'(out_valid), 32'd0);
    drive(1, 25'h0000F6, 0, 1, 0, '0, 0, 0, 1, 0);
    chk("R4 tail still stalls", 32'(enq_ready), 32'd0);
    chk("R4 no loop entry", 32'(looping), 32'd0);
    // R4: lone head stalls
    drive(0, '0, 0, 0, 1, 25'h000107, 1, 0, 1, 0);
    chk("R4 head stalls", 32'(rcq_ready), 32'd0);

    // R9: abort in fill mode has no effect
    push_exp(25'h000118, 0, 0, "R9 forward during abort");
    drive(1, 25'h000118, 0, 0, 0, '0, 0, 0, 1, 1);
    chk("R9 enq forwarded", 32'(enq_ready), 32'd1);
    idle();
    chk("R9 still fill", 32'(looping), 32'd0);

    // R5: markers meet
    drive(1, 25'h000129, 0, 1, 1, 25'h00013A, 1, 0, 1, 0);
    chk("R5 enq_ready at meet", 32'(enq_ready), 32'd1);
    chk("R5 rcq_ready at meet", 32'(rcq_ready), 32'd1);
    chk("R5 nothing output", 32'(out_valid), 32'd0);
    idle();
    chk("R5 loop mode", 32'(looping), 32'd1);

    // R6/R7: loop mode
    push_exp(25'h00015C, 0, 0, "R7 circulate");
    drive(1, 25'h00014B, 0, 0, 1, 25'h00015C, 0, 0, 1, 0);
    chk("R6 enq locked out", 32'(enq_ready), 32'd0);
    chk("R7 feedback taken", 32'(rcq_ready), 32'd1);
    drive(1, 25'h00014B, 0, 0, 1, 25'h00016D, 0, 1, 0, 0);
    chk("R7 backpressure", 32'(rcq_ready), 32'd0);
    chk("R7 out_valid", 32'(out_valid), 32'd1);
    chk("R6 enq locked with stall", 32'(enq_ready), 32'd0);
    push_exp(25'h00016D, 0, 1, "R7 tail-tagged circulate");
    drive(0, '0, 0, 0, 1, 25'h00016D, 0, 1, 1, 0);
    push_exp(25'h00017E, 1, 0, "R7 head-tagged circulate");
    drive(0, '0, 0, 0, 1, 25'h00017E, 1, 0, 1, 0);
    chk("R7 head passes in loop", 32'(rcq_ready), 32'd1);

    // R8: abort leaves loop mode
    drive(0, '0, 0, 0, 0, '0, 0, 0, 1, 1);
    chk("R8 still loop in abort cycle", 32'(looping), 32'd1);
    push_exp(25'h00018F, 0, 0, "R8 fill resumes");
    drive(1, 25'h00018F, 0, 0, 0, '0, 0, 0, 1, 0);
    chk("R8 back to fill", 32'(looping), 32'd0);
    chk("R8 enq accepted", 32'(enq_ready), 32'd1);

    // R10: abort coincides with meeting
    drive(1, 25'h000190, 0, 1, 1, 25'h0001A1, 1, 0, 1, 1);
    chk("R10 enq consumed", 32'(enq_ready), 32'd1);
    chk("R10 rcq consumed", 32'(rcq_ready), 32'd1);
    drive(1, 25'h0001B2, 0, 1, 0, '0, 0, 0, 1, 0);
    chk("R10 stays fill", 32'(looping), 32'd0);
    chk("R10 new tail stalls", 32'(enq_ready), 32'd0);

    idle();
    idle();
    chk("R2/R7 scoreboard drained", 32'(exp_q.size()), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule